// File: doc/BRIEF.md
# Wide Management Request Assembler

This block sits between a 32-bit AXI4-Lite host port and the update port of a lookup table whose entries are wider than one bus word. The host fills a set of staging words with ordinary register writes, names the target table entry in an index register, and then writes a commit register. That commit launches one wide request on a valid/ready output. The request carries the staged data, the entry index, a chunk number and a flag that sets the entry's valid bit.

The request width is the table's response field plus one valid bit, rounded up to the next multiple of 64 bits. An entry too large for one request is sent as several chunks. Only the final chunk raises the valid flag, so lookups never see a half-written entry. An update that touches only the response of an existing entry fits in one chunk with the flag set. The host runs one direction at a time, and the slave serves one transaction at a time. A commit's write response is held back until the table side has taken the request. Staged words persist after a commit, so a following request only rewrites the words that change.

Top module: `wide_req_assembler`

## Requirements
- R1: After reset no response or request is pending (write response, read response and request valid all low), and every staging word, the index register and the commit fields read as zero. A raised write or read response stays raised, with its code unchanged, until the host accepts it.
- R2: Staging word k sits at byte address 0x100 + 4*k. A write updates only the byte lanes whose strobe bit is set, returns OKAY (2'b00), and the word reads back with OKAY.
- R3: The entry index register at 0x004 holds IDX_W bits, written under byte strobes. Written bits above IDX_W are dropped and read back as zero.
- R4: A write to 0x000 commits. Data bit 0 is the last-chunk (valid-set) flag and bits 15:8 are the chunk number; the strobes are ignored. A commit raises the request valid. The request data has staging word k at bits 32k+31:32k, and the request also carries the index register and the given chunk and flag. A read of 0x000 returns the most recent accepted commit in the same bit positions, with all other bits zero.
- R5: The write response of a commit rises in the cycle after the request is accepted (valid and ready high together), never earlier, and is OKAY.
- R6: While a request waits for ready, its data, index, chunk and flag stay stable, and no new read or write is accepted.
- R7: Staging words and the index keep their values after a commit, so a later commit carries the unchanged words again.
- R8: A read or write to any address outside the commit, index and staging words returns SLVERR (2'b10). A read returns zero data, and a write changes no register.
- R9: A commit whose chunk number is NCHUNK or more returns SLVERR, issues no request and leaves the commit fields unchanged.
- R10: Write and read responses are never pending together. When a write (address and data) and a read arrive in the same cycle, the write is served first.
- R11: The staging window holds exactly REQ_W/32 words, with REQ_W equal to RESP_W+1 rounded up to a multiple of 64. With the defaults (RESP_W=71) that is 4 words, and the word at 0x110 is undecoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 13 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 13 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read response valid |
| s_rready | input | 1 | Read response ready |
| m_valid | output | 1 | Wide request valid |
| m_ready | input | 1 | Wide request accepted by the table side |
| m_data | output | REQ_W | Wide request data |
| m_entry | output | IDX_W | Target entry index |
| m_chunk | output | CH_W | Chunk number within the entry |
| m_last | output | 1 | Final chunk: sets the entry valid bit |

## Verification
The bench holds the table-side ready low across a commit. A design that answered the host early, or let the request change while it waited, would show a write response before the handshake or a moving request. It sends commits with an out-of-range chunk number, and accesses one word past the staging window and other undecoded addresses. A design that decoded loosely would then issue a spurious request or corrupt a staging word, and a readback would expose it. Partial strobes, oversized index writes and the collision of a write and a read in one cycle catch designs that ignore lanes, keep high index bits or serve the read first.

// File: rtl/wide_req_assembler.sv
module wide_req_assembler #(
  parameter int RESP_W = 71,
  parameter int IDX_W = 10,
  parameter int NCHUNK = 4,
  localparam int VAL_W = RESP_W + 1,
  localparam int REQ_W = ((VAL_W + 63) / 64) * 64,
  localparam int CH_W = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [12:0]      s_awaddr,
  input  logic             s_awvalid,
  output logic             s_awready,
  input  logic [31:0]      s_wdata,
  input  logic [3:0]       s_wstrb,
  input  logic             s_wvalid,
  output logic             s_wready,
  output logic [1:0]       s_bresp,
  output logic             s_bvalid,
  input  logic             s_bready,
  input  logic [12:0]      s_araddr,
  input  logic             s_arvalid,
  output logic             s_arready,
  output logic [31:0]      s_rdata,
  output logic [1:0]       s_rresp,
  output logic             s_rvalid,
  input  logic             s_rready,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [REQ_W-1:0] m_data,
  output logic [IDX_W-1:0] m_entry,
  output logic [CH_W-1:0]  m_chunk,
  output logic             m_last
);
  localparam int NWORDS = REQ_W / 32;
  localparam int DBASE = 64;
  localparam logic [1:0] RESP_OK = 2'b00;
  localparam logic [1:0] RESP_ERR = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_PUSH, S_BRSP, S_RRSP} state_t;

  state_t           state;
  logic [31:0]      stage [NWORDS];
  logic [IDX_W-1:0] entry_q;
  logic [CH_W-1:0]  chunk_q;
  logic             last_q;
  logic             mvalid_q;
  logic [1:0]       bresp_q, rresp_q;
  logic [31:0]      rdata_q;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v, input logic [31:0] new_v,
                                             input logic [3:0] strb);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction

  logic [10:0] wword, rword;
  logic        wr_go, rd_go;
  logic        w_commit, w_entry, w_data, r_data;
  logic [7:0]  wchunk;
  logic        chunk_ok;
  logic [31:0] ent_wide;
  logic [31:0] rd_val;
  logic        rd_ok;

  assign wword    = s_awaddr[12:2];
  assign rword    = s_araddr[12:2];
  assign wr_go    = (state == S_IDLE) && s_awvalid && s_wvalid;
  assign rd_go    = (state == S_IDLE) && !(s_awvalid && s_wvalid) && s_arvalid;
  assign w_commit = (wword == 11'd0);
  assign w_entry  = (wword == 11'd1);
  assign w_data   = (wword >= 11'(DBASE)) && (wword < 11'(DBASE + NWORDS));
  assign r_data   = (rword >= 11'(DBASE)) && (rword < 11'(DBASE + NWORDS));
  assign wchunk   = s_wdata[15:8];
  assign chunk_ok = ({1'b0, wchunk} < 9'(NCHUNK));
  assign ent_wide = lane_merge(32'(entry_q), s_wdata, s_wstrb);

  always_comb begin
    rd_val = '0;
    rd_ok  = 1'b1;
    if (rword == 11'd0) begin
      rd_val[15:8] = 8'(chunk_q);
      rd_val[0]    = last_q;
    end else if (rword == 11'd1) begin
      rd_val = 32'(entry_q);
    end else if (r_data) begin
      for (int i = 0; i < NWORDS; i++)
        if (rword == 11'(DBASE + i)) rd_val = stage[i];
    end else begin
      rd_ok = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      entry_q  <= '0;
      chunk_q  <= '0;
      last_q   <= 1'b0;
      mvalid_q <= 1'b0;
      bresp_q  <= RESP_OK;
      rresp_q  <= RESP_OK;
      rdata_q  <= '0;
      for (int i = 0; i < NWORDS; i++) stage[i] <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wr_go) begin
            bresp_q <= RESP_OK;
            state   <= S_BRSP;
            if (w_commit && chunk_ok) begin
              mvalid_q <= 1'b1;
              chunk_q  <= wchunk[CH_W-1:0];
              last_q   <= s_wdata[0];
              state    <= S_PUSH;
            end else if (w_entry) begin
              entry_q <= ent_wide[IDX_W-1:0];
            end else if (w_data) begin
              for (int i = 0; i < NWORDS; i++)
                if (wword == 11'(DBASE + i)) stage[i] <= lane_merge(stage[i], s_wdata, s_wstrb);
            end else begin
              bresp_q <= RESP_ERR;
            end
          end else if (rd_go) begin
            rdata_q <= rd_ok ? rd_val : 32'h0;
            rresp_q <= rd_ok ? RESP_OK : RESP_ERR;
            state   <= S_RRSP;
          end
        end
        S_PUSH: begin
          if (m_ready) begin
            mvalid_q <= 1'b0;
            state    <= S_BRSP;
          end
        end
        S_BRSP: if (s_bready) state <= S_IDLE;
        S_RRSP: if (s_rready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NWORDS; g++) begin : g_pack
    assign m_data[32*g +: 32] = stage[g];
  end

  assign s_awready = wr_go;
  assign s_wready  = wr_go;
  assign s_arready = rd_go;
  assign s_bvalid  = (state == S_BRSP);
  assign s_bresp   = bresp_q;
  assign s_rvalid  = (state == S_RRSP);
  assign s_rresp   = rresp_q;
  assign s_rdata   = rdata_q;
  assign m_valid   = mvalid_q;
  assign m_entry   = entry_q;
  assign m_chunk   = chunk_q;
  assign m_last    = last_q;

  logic unused_ok;
  assign unused_ok = ^{s_awaddr[1:0], s_araddr[1:0], ent_wide};
endmodule

module wra_checks #(
  parameter int REQ_W = 128,
  parameter int IDX_W = 10,
  parameter int CH_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_awready,
  input logic             s_wready,
  input logic             s_arready,
  input logic             s_bvalid,
  input logic             s_bready,
  input logic [1:0]       s_bresp,
  input logic             s_rvalid,
  input logic             s_rready,
  input logic [1:0]       s_rresp,
  input logic [31:0]      s_rdata,
  input logic             m_valid,
  input logic             m_ready,
  input logic [REQ_W-1:0] m_data,
  input logic [IDX_W-1:0] m_entry,
  input logic [CH_W-1:0]  m_chunk,
  input logic             m_last
);
  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_entry) && $stable(m_chunk) && $stable(m_last));
  a_r6_no_accept_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_awready && !s_wready && !s_arready);
  a_r5_no_early_bresp: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_bvalid);
  a_r5_bresp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready |=> s_bvalid && s_bresp == 2'b00);
  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_bvalid && s_rvalid));
  a_r1_bresp_held: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
  a_r1_rresp_held: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rresp) && $stable(s_rdata));
  a_r8_error_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && s_rresp == 2'b10 |-> s_rdata == 32'h0);
endmodule

bind wide_req_assembler wra_checks #(.REQ_W(REQ_W), .IDX_W(IDX_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_awready(s_awready), .s_wready(s_wready), .s_arready(s_arready),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp), .s_rvalid(s_rvalid),
  .s_rready(s_rready), .s_rresp(s_rresp), .s_rdata(s_rdata), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_entry(m_entry), .m_chunk(m_chunk), .m_last(m_last));

// File: tb/sim_wide_req_assembler.sv
module sim_wide_req_assembler;
  localparam int RESP_W = 71;
  localparam int IDX_W = 10;
  localparam int NCHUNK = 4;
  localparam int TW = ((RESP_W + 1 + 63) / 64) * 64;
  localparam int NW = TW / 32;
  localparam int CH_W = 2;

  logic clk = 0, rst_n = 0;
  logic [12:0] s_awaddr = '0, s_araddr = '0;
  logic s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
  logic s_bready = 1, s_rready = 1, m_ready = 1;
  logic [31:0] s_wdata = '0;
  logic [3:0] s_wstrb = '0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid, m_valid, m_last;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [TW-1:0] m_data;
  logic [IDX_W-1:0] m_entry;
  logic [CH_W-1:0] m_chunk;

  wide_req_assembler #(.RESP_W(RESP_W), .IDX_W(IDX_W), .NCHUNK(NCHUNK)) u0 (
    .clk(clk), .rst_n(rst_n), .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_araddr(s_araddr),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .m_entry(m_entry), .m_chunk(m_chunk), .m_last(m_last));

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int rmode = 0;
  int cap_n = 0, hs_cyc = 0;
  logic [TW-1:0] cap_d;
  logic [IDX_W-1:0] cap_e;
  logic [CH_W-1:0] cap_c;
  logic cap_l;

  logic [31:0] ms [NW];
  logic [IDX_W-1:0] ment = '0;
  logic [7:0] mchunk = '0;
  logic mlast = 0;

  task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial forever begin
    @(negedge clk);
    case (rmode)
      0: m_ready = 1'b1;
      1: m_ready = 1'($urandom % 2);
      default: m_ready = 1'b0;
    endcase
    #1;
    if (m_valid && m_ready) begin
      cap_n++; cap_d = m_data; cap_e = m_entry; cap_c = m_chunk; cap_l = m_last; hs_cyc = cyc;
    end
  end

  function automatic logic [31:0] lanes(input logic [31:0] o, input logic [31:0] n, input logic [3:0] st);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = st[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  function automatic logic [TW-1:0] exp_data();
    logic [TW-1:0] r;
    for (int k = 0; k < NW; k++) r[32*k +: 32] = ms[k];
    return r;
  endfunction

  function automatic logic [33:0] exp_read(input logic [12:0] a);
    int w = int'(a[12:2]);
    if (w == 0) return {2'b00, 16'h0, mchunk, 7'h0, mlast};
    if (w == 1) return {2'b00, 32'(ment)};
    if (w >= 64 && w < 64 + NW) return {2'b00, ms[w-64]};
    return {2'b10, 32'h0};
  endfunction

  task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] st,
                    output logic [1:0] resp, output int bcyc);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st; s_awvalid = 1; s_wvalid = 1;
    #2;
    while (!(s_awready && s_wready)) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    s_awvalid = 0; s_wvalid = 0;
    @(negedge clk); #2;
    while (!s_bvalid) begin @(negedge clk); #2; end
    resp = s_bresp; bcyc = cyc;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d, output logic [1:0] resp, output int rcyc);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    #2;
    while (!s_arready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    s_arvalid = 0;
    @(negedge clk); #2;
    while (!s_rvalid) begin @(negedge clk); #2; end
    d = s_rdata; resp = s_rresp; rcyc = cyc;
  endtask

  task automatic do_rd(input logic [12:0] a, input string rq);
    logic [31:0] d; logic [1:0] r; int c;
    logic [33:0] e = exp_read(a);
    rd(a, d, r, c);
    chk({rq, " read resp"}, 256'(r), 256'(e[33:32]));
    chk({rq, " read data"}, 256'(d), 256'(e[31:0]));
  endtask

  task automatic do_wdata(input int k, input logic [31:0] d, input logic [3:0] st);
    logic [1:0] r; int c;
    wr(13'(256 + 4*k), d, st, r, c);
    if (k < NW) begin
      ms[k] = lanes(ms[k], d, st);
      chk("R2 staging write resp", 256'(r), 256'(2'b00));
    end else begin
      chk("R11 past-window write resp", 256'(r), 256'(2'b10));
    end
  endtask

  task automatic do_entry(input logic [31:0] d, input logic [3:0] st);
    logic [1:0] r; int c;
    logic [31:0] t = lanes(32'(ment), d, st);
    wr(13'h004, d, st, r, c);
    ment = t[IDX_W-1:0];
    chk("R3 index write resp", 256'(r), 256'(2'b00));
  endtask

  task automatic do_commit(input logic [7:0] ch, input logic lst);
    logic [1:0] r; int bc;
    int n0 = cap_n;
    wr(13'h000, {16'h0, ch, 7'h0, lst}, 4'(($urandom % 2) * 15), r, bc);
    if (ch < NCHUNK) begin
      chk("R4 one request issued", 256'(cap_n), 256'(n0 + 1));
      chk("R4 request data", 256'(cap_d), 256'(exp_data()));
      chk("R4 request index", 256'(cap_e), 256'(ment));
      chk("R4 request chunk", 256'(cap_c), 256'(ch[CH_W-1:0]));
      chk("R4 request last flag", 256'(cap_l), 256'(lst));
      chk("R5 commit resp", 256'(r), 256'(2'b00));
      chk("R5 bresp one cycle after accept", 256'(bc), 256'(hs_cyc + 1));
      mchunk = ch; mlast = lst;
    end else begin
      chk("R9 bad chunk resp", 256'(r), 256'(2'b10));
      chk("R9 no request", 256'(cap_n), 256'(n0));
    end
  endtask

  initial begin
    void'($urandom(32'd7319));
    for (int k = 0; k < NW; k++) ms[k] = '0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk("R1 bvalid after reset", 256'(s_bvalid), 256'(0));
    chk("R1 rvalid after reset", 256'(s_rvalid), 256'(0));
    chk("R1 request valid after reset", 256'(m_valid), 256'(0));
    for (int k = 0; k < NW; k++) do_rd(13'(256 + 4*k), "R1 staging reset");
    do_rd(13'h004, "R1 index reset");
    do_rd(13'h000, "R1 commit reset");

    for (int k = 0; k < NW; k++) do_wdata(k, 32'hA5000000 + 32'(k * 17), 4'hF);
    do_wdata(2, 32'h1122_3344, 4'b0101);
    for (int k = 0; k < NW; k++) do_rd(13'(256 + 4*k), "R2 staging readback");
    do_entry(32'hFFFF_FFFF, 4'hF);
    do_rd(13'h004, "R3 index upper bits dropped");
    do_entry(32'h0000_0123, 4'b0001);
    do_rd(13'h004, "R3 index strobes");

    do_commit(8'd1, 1'b0);
    do_rd(13'h000, "R4 commit readback");

    rmode = 2;
    fork do_commit(8'd2, 1'b0); join_none
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #3;
      chk("R6 request held while stalled", 256'(m_valid), 256'(1));
      chk("R5 no bresp before accept", 256'(s_bvalid), 256'(0));
      chk("R6 request data stable", 256'(m_data), 256'(exp_data()));
    end
    rmode = 0;
    wait fork;

    do_wdata(1, 32'hDEAD_BEEF, 4'hF);
    do_commit(8'd3, 1'b1);
    chk("R7 untouched word carried", 256'(cap_d[31:0]), 256'(ms[0]));
    for (int k = 0; k < NW; k++) do_rd(13'(256 + 4*k), "R7 staging kept");

    begin
      logic [1:0] r; int c;
      wr(13'h008, 32'hFFFF_FFFF, 4'hF, r, c);
      chk("R8 undecoded write resp", 256'(r), 256'(2'b10));
      wr(13'h1FFC, 32'hFFFF_FFFF, 4'hF, r, c);
      chk("R8 top address write resp", 256'(r), 256'(2'b10));
    end
    for (int k = 0; k < NW; k++) do_rd(13'(256 + 4*k), "R8 no side effect");
    do_rd(13'h004, "R8 index untouched");
    do_rd(13'h008, "R8 undecoded read");
    do_wdata(NW, 32'h5555_AAAA, 4'hF);
    do_rd(13'(256 + 4*NW), "R11 past-window read");
    for (int k = 0; k < NW; k++) do_rd(13'(256 + 4*k), "R11 window intact");

    do_commit(8'(NCHUNK), 1'b1);
    do_commit(8'hFF, 1'b0);
    do_rd(13'h000, "R9 commit fields unchanged");

    begin
      logic [1:0] wr_r, rd_r; int bc, rc; logic [31:0] d;
      ms[3] = 32'h0BAD_F00D;
      fork
        wr(13'h10C, 32'h0BAD_F00D, 4'hF, wr_r, bc);
        rd(13'h10C, d, rd_r, rc);
      join
      chk("R10 write served first", 256'(bc < rc), 256'(1));
      chk("R10 read sees prior write", 256'(d), 256'(32'h0BAD_F00D));
    end

    rmode = 1;
    for (int i = 0; i < 300; i++) begin
      int op = int'($urandom % 6);
      case (op)
        0, 1: do_wdata(int'($urandom % (NW + 1)), $urandom, 4'($urandom));
        2: do_entry($urandom, 4'($urandom));
        3: do_commit(8'($urandom % (NCHUNK + 2)), 1'($urandom));
        4: do_rd(13'(256 + 4 * ($urandom % (NW + 1))), "R2 random read");
        default: do_rd(13'(4 * ($urandom % 2048)), "R8 random address read");
      endcase
    end
    rmode = 0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule